// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block divides a clock, or a stream of reference edges, by an integer that software sets. A 16-bit down-path counter sets the base ratio. A divide-by-2 stage after it can be switched in. A control bit picks which input edge does the counting: rising or falling. The modulus input holds the ratio minus one. A value of zero therefore gives divide-by-one. With the halving stage off, the ratio runs from 1 to 65,536. With it on, only even ratios are possible, from 2 to 131,072.

The block runs on the signal being divided. The edge-select bit is applied to that signal to form the internal counting clock, so every register and the synchronous reset act on the selected edge. The control inputs are treated as quasi-static. Software must enable the halving stage for fast inputs and must check frequency limits. The block only provides the stages.

There are two outputs:
- A terminal-count strobe, which is high for one input cycle each time the counter wraps.
- A divided output. By default it is a one-cycle pulse at the end of each full division period. Optionally it is a 50% duty square wave taken from the toggle flip-flop.

Top module: `clk_int_divider`

## Requirements
- R1: With modulus value V, `tc_strobe` is high for exactly one input cycle after every (V+1)-th active edge counted from reset release, and low after all other active edges.
- R2: With V = 0 and `halve_en` = 0, `tc_strobe` and `div_out` (pulse mode) are high after every active edge.
- R3: With `halve_en` = 1 and `square_mode` = 0, `div_out` pulses for one cycle only at every second counter wrap: after active edges 2(V+1), 4(V+1), and so on.
- R4: With `halve_en` = 0 and `square_mode` = 0, `div_out` pulses after the same edges as `tc_strobe`.
- R5: With `square_mode` = 1, `div_out` is the toggle flip-flop. It rises at the first counter wrap and changes at every wrap after that, giving V+1 cycles high and V+1 cycles low.
- R6: With `fall_edge` = 0, the block counts on rising edges of `clk_in`. With `fall_edge` = 1, it counts on falling edges. The outputs change only just after the selected edge and hold steady across the other edge.
- R7: A change to `mod_val` in the middle of a period does not shorten or lengthen that period. The new value takes effect from the next wrap.
- R8: While `rst` is sampled high at an active edge, the counter and toggle flip-flop clear and both outputs go low. The latched modulus is reloaded from `mod_val`.
- R9: The counter covers the full 16-bit range. A V wider than 8 bits (for example V = 300) divides by exactly V+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Signal being divided; also the block clock |
| rst | input | 1 | Synchronous reset, active high, sampled on the selected edge |
| mod_val | input | 16 | Division ratio minus one |
| halve_en | input | 1 | Enables the divide-by-2 stage after the counter |
| fall_edge | input | 1 | 0: count rising edges, 1: count falling edges |
| square_mode | input | 1 | 0: pulse output, 1: 50% duty toggle output |
| div_out | output | 1 | Divided pulse or square wave |
| tc_strobe | output | 1 | One-cycle strobe at each counter wrap |

## Verification
A counter that skips or repeats a state shifts every later `tc_strobe` by one edge. This shows within one division period of the fault. A toggle flip-flop with the wrong phase inverts the square output, or moves the halved pulse onto the odd wraps, so the first full period after reset reveals it. A modulus latched at the wrong time shortens or stretches the period that is in progress when `mod_val` changes, which is visible at the very next wrap. Counting on the wrong edge moves every output change by half an input cycle, so sampling both just after and just before the selected edge exposes it.

// File: rtl/clk_int_divider.sv
module clk_int_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             halve_en,
  input  logic             fall_edge,
  input  logic             square_mode,
  output logic             div_out,
  output logic             tc_strobe
);

  logic             cnt_clk;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             wrap;
  logic             half_q;
  logic             tc_q;
  logic             pulse_q;

  assign cnt_clk = clk_in ^ fall_edge;
  assign wrap    = (cnt == lim);

  always_ff @(posedge cnt_clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= mod_val;
    end else if (wrap) begin
      cnt <= '0;
      lim <= mod_val;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge cnt_clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      tc_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      tc_q    <= wrap;
      pulse_q <= wrap & (~halve_en | half_q);
      if (wrap) half_q <= ~half_q;
    end
  end

  assign tc_strobe = tc_q;
  assign div_out   = square_mode ? half_q : pulse_q;

  AST_CNT_BOUND: assert property (@(posedge cnt_clk) disable iff (rst)
    cnt <= lim); // R1
  AST_LIM_HOLD: assert property (@(posedge cnt_clk) disable iff (rst)
    !wrap |=> $stable(lim)); // R7
  AST_PASS_THRU: assert property (@(posedge cnt_clk) disable iff (rst)
    (lim == '0 && !halve_en) |=> (tc_q && pulse_q)); // R2
  AST_PULSE_IN_TC: assert property (@(posedge cnt_clk) disable iff (rst)
    pulse_q |-> tc_q); // R3
  AST_HALF_FLIP: assert property (@(posedge cnt_clk) disable iff (rst)
    tc_q |-> (half_q != $past(half_q))); // R5
  AST_RST_CLEAR: assert property (@(posedge cnt_clk)
    rst |=> (cnt == '0 && !half_q && !tc_q && !pulse_q)); // R8

endmodule

// File: tb/clk_int_divider_bench.sv
module clk_int_divider_bench;
  localparam int PERIOD = 10;

  logic        clk_in = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mod_val = '0;
  logic        halve_en = 1'b0;
  logic        fall_edge = 1'b0;
  logic        square_mode = 1'b0;
  logic        div_out;
  logic        tc_strobe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  clk_int_divider u_clk_int_divider (
    .clk_in(clk_in), .rst(rst), .mod_val(mod_val), .halve_en(halve_en),
    .fall_edge(fall_edge), .square_mode(square_mode),
    .div_out(div_out), .tc_strobe(tc_strobe)
  );

  always #(PERIOD/2) clk_in = ~clk_in;

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    if (fall_edge) @(negedge clk_in); else @(posedge clk_in);
    #1;
  endtask

  task automatic hold_check();
    logic d, t;
    d = div_out; t = tc_strobe;
    if (fall_edge) @(posedge clk_in); else @(negedge clk_in);
    #1;
    chk("R6", "div_out across other edge", div_out, d);
    chk("R6", "tc_strobe across other edge", tc_strobe, t);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    chk("R8", "div_out in reset", div_out, 1'b0);
    chk("R8", "tc_strobe in reset", tc_strobe, 1'b0);
    rst = 1'b0;
  endtask

  task automatic run_case(string req, int v, bit hv, bit sq, bit fe, int edges);
    int n;
    logic e_tc, e_div;
    n = v + 1;
    fall_edge = fe; mod_val = 16'(v); halve_en = hv; square_mode = sq;
    step();
    do_reset();
    for (int k = 1; k <= edges; k++) begin
      step();
      e_tc = (k % n == 0);
      if (sq) e_div = ((k / n) % 2 == 1);
      else if (hv) e_div = e_tc && ((k / n) % 2 == 0);
      else e_div = e_tc;
      chk(req, "tc_strobe (R1)", tc_strobe, e_tc);
      chk(req, "div_out", div_out, e_div);
      if (k <= 6) hold_check();
    end
  endtask

  task automatic test_basic();      run_case("R1/R4", 4, 0, 0, 0, 30); endtask
  task automatic test_pass();       run_case("R2", 0, 0, 0, 0, 12); endtask
  task automatic test_halve();      run_case("R3", 2, 1, 0, 0, 36); endtask
  task automatic test_halve_min();  run_case("R3", 0, 1, 0, 0, 12); endtask
  task automatic test_square();     run_case("R5", 3, 0, 1, 0, 40); endtask
  task automatic test_falling();    run_case("R6", 2, 1, 0, 1, 30); endtask
  task automatic test_falling_sq(); run_case("R6/R5", 1, 0, 1, 1, 16); endtask
  task automatic test_wide();       run_case("R9", 300, 0, 0, 0, 650); endtask

  task automatic test_mod_change();
    logic e;
    fall_edge = 0; halve_en = 0; square_mode = 0; mod_val = 16'd4;
    step();
    do_reset();
    for (int k = 1; k <= 16; k++) begin
      step();
      if (k == 7) mod_val = 16'd1;
      e = (k == 5) || (k == 10) || (k > 10 && k % 2 == 0);
      chk("R7", "tc_strobe after modulus change", tc_strobe, e);
    end
  endtask

  task automatic test_reset_midrun();
    fall_edge = 0; halve_en = 0; square_mode = 1; mod_val = 16'd2;
    step();
    do_reset();
    for (int k = 1; k <= 4; k++) step();
    chk("R8", "square high before reset", div_out, 1'b1);
    rst = 1'b1; step();
    chk("R8", "square cleared by reset", div_out, 1'b0);
    rst = 1'b0;
    step(); step();
    chk("R8", "no wrap at edge 2", tc_strobe, 1'b0);
    step();
    chk("R8", "wrap at edge 3 after release", tc_strobe, 1'b1);
    chk("R8", "square rises at first wrap", div_out, 1'b1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    test_basic();
    test_pass();
    test_halve();
    test_halve_min();
    test_square();
    test_falling();
    test_falling_sq();
    test_wide();
    test_mod_change();
    test_reset_midrun();
    done = 1;
    finish_run();
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      finish_run();
    end
  end
endmodule